// File: doc/BRIEF.md
# PLL Power and Bypass Sequencer

This block is the control state machine placed between a configuration register interface and the control pins of an analog PLL. It drives the PLL's power-down control, reads back its lock indication through a synchronizer, drives the divider and charge-pump codes, and steers the downstream clock multiplexer between the reference bypass path and the PLL output. Each move of the multiplexer is ordered against the power and lock state. The multiplexer is released onto the PLL only after lock has been observed, and it is returned to bypass before the PLL is powered down.

Software issues single-cycle requests: power up, power down, or reprogram with a new divider set. A reprogram always runs as a full cycle. The PLL is taken down if it is running, the feedback divider, input divider and charge-pump codes are loaded one per cycle in that order, and the PLL is then brought back up. The lock wait is bounded by a cycle counter sized from the clock frequency and a timeout in microseconds. Each sequence ends with a one-cycle done pulse, and a timeout flag tells whether it ended without lock. A request that arrives while a sequence is running is refused with a one-cycle reject pulse. A rate-valid output tells the consumer whether the PLL output can be trusted.

Top module: `pll_pwr_seq`

## Requirements
- R1: After synchronous reset, power_down_o=1, bypass_o=1, busy_o=0, done_o=0, timeout_o=0, reject_o=0 and rate_valid_o=0, and the divider outputs hold RST_NDIV, RST_IDF and RST_CP.
- R2: An enable request while power_down_o=1 drives power_down_o to 0 and waits for the synchronized lock. bypass_o goes to 0 only on the edge after lock is seen, in the same cycle as the done pulse, with timeout_o=0.
- R3: An enable request while power_down_o=0 produces done_o in the cycle after the request and changes no other output.
- R4: If lock is not seen within TMO_CYC=(CLK_HZ/1e6)*TIMEOUT_US cycles, counted from the fall of power_down_o, the sequence ends with done_o and timeout_o=1. power_down_o stays 0 and bypass_o stays 1. timeout_o clears when the next request is accepted.
- R5: A disable request while powered sets bypass_o to 1, and on the following cycle sets power_down_o to 1 and pulses done_o. power_down_o never rises unless bypass_o was 1 in the cycle before.
- R6: A disable request while power_down_o=1 produces done_o in the cycle after the request and changes no other output.
- R7: A reprogram request captures new_ndiv_i, new_idf_i and new_cp_i in the request cycle. It runs the disable sequence if the PLL is powered, then updates ndiv_o, idf_o and cp_o on three consecutive cycles in that order while power_down_o=1, then runs the enable sequence.
- R8: rate_valid_o is 1 only when the PLL is powered and the synchronized lock is 1, with one cycle of lag. It is 0 while power_down_o has been 1 for two cycles or more, and 0 while lock is absent.
- R9: busy_o is 1 while a sequence runs. Any request during that time gives a reject_o pulse in the next cycle and does not alter the running sequence or its result.
- R10: When several requests arrive together in idle, reprogram wins over disable and disable wins over enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_enable_i | input | 1 | Power-up request pulse |
| req_disable_i | input | 1 | Power-down request pulse |
| req_reprog_i | input | 1 | Reprogram request pulse |
| new_ndiv_i | input | NDIV_W | Feedback divider code for reprogram |
| new_idf_i | input | IDF_W | Input divider code for reprogram |
| new_cp_i | input | CP_W | Charge-pump code for reprogram |
| pll_lock_i | input | 1 | Asynchronous lock indication from the PLL |
| power_down_o | output | 1 | PLL power-down control, 1 = off |
| bypass_o | output | 1 | Clock mux select, 1 = reference bypass, 0 = PLL |
| ndiv_o | output | NDIV_W | Feedback divider code to the PLL |
| idf_o | output | IDF_W | Input divider code to the PLL |
| cp_o | output | CP_W | Charge-pump code to the PLL |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |
| timeout_o | output | 1 | Last sequence ended without lock |
| reject_o | output | 1 | One-cycle pulse for a refused request |
| rate_valid_o | output | 1 | PLL output usable |

## Verification
The ordering assertions assume that the lock input is low whenever the PLL is powered down. They also assume that lock falls quickly enough after power-down to clear the synchronizer before the next lock wait begins. The bench's PLL model ties lock to the power-down pin and raises it a fixed delay after power-up, so both assumptions hold. Requests are single-cycle pulses driven between clock edges. The bench spaces them so that a done pulse and a reject pulse never fall in the same cycle, which keeps the order of the scoreboard queue unambiguous. The timeout case runs with a shortened clock-frequency parameter and a lock model that never asserts lock, so the full wait fits inside a short run.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BYPASS,
    ST_PWRDN,
    ST_LD_NDIV,
    ST_LD_IDF,
    ST_LD_CP,
    ST_PWRUP,
    ST_WAIT_LOCK
  } seq_state_e;

  function automatic int tmo_cycles(input int clk_hz, input int tmo_us);
    return (clk_hz / 1000000) * tmo_us;
  endfunction

endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];

  initial begin
    assert (STAGES >= 2);
  end
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int LIMIT = 1000,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic run_i,
  output logic expire_o
);
  logic [CW-1:0] cnt_q;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  always_ff @(posedge clk) begin
    if (rst || clr_i)                 cnt_q <= '0;
    else if (run_i && cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == LAST);

  // R4: the wait counter never passes the timeout bound
  assert_timer_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/pll_div_regs.sv
module pll_div_regs #(
  parameter int NDIV_W = 8,
  parameter int IDF_W  = 3,
  parameter int CP_W   = 5,
  parameter logic [NDIV_W-1:0] RST_NDIV = '0,
  parameter logic [IDF_W-1:0]  RST_IDF  = '0,
  parameter logic [CP_W-1:0]   RST_CP   = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stage_we_i,
  input  logic [NDIV_W-1:0] new_ndiv_i,
  input  logic [IDF_W-1:0]  new_idf_i,
  input  logic [CP_W-1:0]   new_cp_i,
  input  logic              ld_ndiv_i,
  input  logic              ld_idf_i,
  input  logic              ld_cp_i,
  output logic [NDIV_W-1:0] ndiv_o,
  output logic [IDF_W-1:0]  idf_o,
  output logic [CP_W-1:0]   cp_o
);
  logic [NDIV_W-1:0] stg_ndiv_q;
  logic [IDF_W-1:0]  stg_idf_q;
  logic [CP_W-1:0]   stg_cp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_ndiv_q <= RST_NDIV;
      stg_idf_q  <= RST_IDF;
      stg_cp_q   <= RST_CP;
    end else if (stage_we_i) begin
      stg_ndiv_q <= new_ndiv_i;
      stg_idf_q  <= new_idf_i;
      stg_cp_q   <= new_cp_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ndiv_o <= RST_NDIV;
      idf_o  <= RST_IDF;
      cp_o   <= RST_CP;
    end else begin
      if (ld_ndiv_i) ndiv_o <= stg_ndiv_q;
      if (ld_idf_i)  idf_o  <= stg_idf_q;
      if (ld_cp_i)   cp_o   <= stg_cp_q;
    end
  end

  // R7: input divider is written only the cycle after the feedback divider
  assert_idf_after_ndiv_R7: assert property (@(posedge clk) disable iff (rst)
    ld_idf_i |-> $past(ld_ndiv_i));
  // R7: charge pump is written only the cycle after the input divider
  assert_cp_after_idf_R7: assert property (@(posedge clk) disable iff (rst)
    ld_cp_i |-> $past(ld_idf_i));
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_en_i,
  input  logic req_dis_i,
  input  logic req_rp_i,
  input  logic lock_i,
  input  logic tmr_exp_i,
  output logic pdn_o,
  output logic byp_o,
  output logic done_o,
  output logic tmo_o,
  output logic rej_o,
  output logic busy_o,
  output logic tmr_clr_o,
  output logic tmr_run_o,
  output logic stage_we_o,
  output logic ld_ndiv_o,
  output logic ld_idf_o,
  output logic ld_cp_o
);
  seq_state_e state_q;
  logic       rp_q;
  logic       any_req;

  assign any_req = req_en_i | req_dis_i | req_rp_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pdn_o   <= 1'b1;
      byp_o   <= 1'b1;
      done_o  <= 1'b0;
      tmo_o   <= 1'b0;
      rej_o   <= 1'b0;
      rp_q    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      rej_o  <= (state_q != ST_IDLE) && any_req;
      unique case (state_q)
        ST_IDLE: begin
          if (req_rp_i) begin
            tmo_o   <= 1'b0;
            rp_q    <= 1'b1;
            state_q <= pdn_o ? ST_LD_NDIV : ST_BYPASS;
          end else if (req_dis_i) begin
            tmo_o <= 1'b0;
            if (pdn_o) done_o  <= 1'b1;
            else       state_q <= ST_BYPASS;
          end else if (req_en_i) begin
            tmo_o <= 1'b0;
            if (!pdn_o) done_o  <= 1'b1;
            else        state_q <= ST_PWRUP;
          end
        end
        ST_BYPASS: begin
          byp_o   <= 1'b1;
          state_q <= ST_PWRDN;
        end
        ST_PWRDN: begin
          pdn_o <= 1'b1;
          if (rp_q) state_q <= ST_LD_NDIV;
          else begin
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_LD_NDIV: state_q <= ST_LD_IDF;
        ST_LD_IDF:  state_q <= ST_LD_CP;
        ST_LD_CP:   state_q <= ST_PWRUP;
        ST_PWRUP: begin
          pdn_o   <= 1'b0;
          state_q <= ST_WAIT_LOCK;
        end
        ST_WAIT_LOCK: begin
          if (lock_i) begin
            byp_o   <= 1'b0;
            done_o  <= 1'b1;
            rp_q    <= 1'b0;
            state_q <= ST_IDLE;
          end else if (tmr_exp_i) begin
            tmo_o   <= 1'b1;
            done_o  <= 1'b1;
            rp_q    <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign tmr_clr_o  = (state_q == ST_PWRUP);
  assign tmr_run_o  = (state_q == ST_WAIT_LOCK);
  assign stage_we_o = (state_q == ST_IDLE) && req_rp_i;
  assign ld_ndiv_o  = (state_q == ST_LD_NDIV);
  assign ld_idf_o   = (state_q == ST_LD_IDF);
  assign ld_cp_o    = (state_q == ST_LD_CP);

  // R5: power-down rises only after bypass was already selected
  assert_byp_before_pdn_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(pdn_o) |-> $past(byp_o));
  // R2: mux leaves bypass only after lock was seen on a powered PLL
  assert_switch_after_lock_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(byp_o) |-> ($past(lock_i) && !$past(pdn_o)));
  // R9: a reject pulse only follows a request made while busy
  assert_reject_when_busy_R9: assert property (@(posedge clk) disable iff (rst)
    rej_o |-> ($past(busy_o) && $past(any_req)));
  // R4: a timeout ends with the PLL powered and the mux in bypass
  assert_timeout_state_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(tmo_o) |-> (!pdn_o && byp_o && done_o));
endmodule

// File: rtl/pll_pwr_seq.sv
module pll_pwr_seq
  import pll_seq_pkg::*;
#(
  parameter int CLK_HZ      = 125000000,
  parameter int TIMEOUT_US  = 10000,
  parameter int SYNC_STAGES = 2,
  parameter int NDIV_W      = 8,
  parameter int IDF_W       = 3,
  parameter int CP_W        = 5,
  parameter logic [NDIV_W-1:0] RST_NDIV = NDIV_W'(50),
  parameter logic [IDF_W-1:0]  RST_IDF  = IDF_W'(1),
  parameter logic [CP_W-1:0]   RST_CP   = CP_W'(6)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_enable_i,
  input  logic              req_disable_i,
  input  logic              req_reprog_i,
  input  logic [NDIV_W-1:0] new_ndiv_i,
  input  logic [IDF_W-1:0]  new_idf_i,
  input  logic [CP_W-1:0]   new_cp_i,
  input  logic              pll_lock_i,
  output logic              power_down_o,
  output logic              bypass_o,
  output logic [NDIV_W-1:0] ndiv_o,
  output logic [IDF_W-1:0]  idf_o,
  output logic [CP_W-1:0]   cp_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              reject_o,
  output logic              rate_valid_o
);
  localparam int TMO_CYC = tmo_cycles(CLK_HZ, TIMEOUT_US);

  logic lock_s;
  logic tmr_clr, tmr_run, tmr_exp;
  logic stage_we, ld_ndiv, ld_idf, ld_cp;

  pll_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(pll_lock_i), .sync_o(lock_s));

  pll_lock_timer #(.LIMIT(TMO_CYC)) u_timer (
    .clk(clk), .rst(rst), .clr_i(tmr_clr), .run_i(tmr_run), .expire_o(tmr_exp));

  pll_seq_fsm u_fsm (
    .clk(clk), .rst(rst),
    .req_en_i(req_enable_i), .req_dis_i(req_disable_i), .req_rp_i(req_reprog_i),
    .lock_i(lock_s), .tmr_exp_i(tmr_exp),
    .pdn_o(power_down_o), .byp_o(bypass_o), .done_o(done_o), .tmo_o(timeout_o),
    .rej_o(reject_o), .busy_o(busy_o), .tmr_clr_o(tmr_clr), .tmr_run_o(tmr_run),
    .stage_we_o(stage_we), .ld_ndiv_o(ld_ndiv), .ld_idf_o(ld_idf), .ld_cp_o(ld_cp));

  pll_div_regs #(
    .NDIV_W(NDIV_W), .IDF_W(IDF_W), .CP_W(CP_W),
    .RST_NDIV(RST_NDIV), .RST_IDF(RST_IDF), .RST_CP(RST_CP)
  ) u_div (
    .clk(clk), .rst(rst), .stage_we_i(stage_we),
    .new_ndiv_i(new_ndiv_i), .new_idf_i(new_idf_i), .new_cp_i(new_cp_i),
    .ld_ndiv_i(ld_ndiv), .ld_idf_i(ld_idf), .ld_cp_i(ld_cp),
    .ndiv_o(ndiv_o), .idf_o(idf_o), .cp_o(cp_o));

  always_ff @(posedge clk) begin
    if (rst) rate_valid_o <= 1'b0;
    else     rate_valid_o <= !power_down_o && lock_s;
  end

  // R8: no valid rate once the PLL has been off for a full cycle
  assert_rate_off_R8: assert property (@(posedge clk) disable iff (rst)
    (power_down_o && $past(power_down_o)) |-> !rate_valid_o);
  // R7: divider codes only move while the PLL is powered down
  assert_div_change_off_R7: assert property (@(posedge clk) disable iff (rst)
    (!$stable(ndiv_o) || !$stable(idf_o) || !$stable(cp_o)) |-> power_down_o);
endmodule

// File: tb/sim_pll_pwr_seq.sv
`timescale 1ns/1ps
module sim_pll_pwr_seq;
  localparam int LIMIT    = 40;
  localparam int LOCK_DLY = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_en = 1'b0, req_dis = 1'b0, req_rp = 1'b0;
  logic [7:0] n_in = '0;
  logic [2:0] i_in = '0;
  logic [4:0] c_in = '0;
  logic pll_lock;
  logic pdn, byp, busy, done, tmo, rej, rv;
  logic [7:0] ndiv;
  logic [2:0] idf;
  logic [4:0] cp;

  always #4 clk = ~clk;

  pll_pwr_seq #(.CLK_HZ(1000000), .TIMEOUT_US(LIMIT)) u0 (
    .clk(clk), .rst(rst),
    .req_enable_i(req_en), .req_disable_i(req_dis), .req_reprog_i(req_rp),
    .new_ndiv_i(n_in), .new_idf_i(i_in), .new_cp_i(c_in),
    .pll_lock_i(pll_lock),
    .power_down_o(pdn), .bypass_o(byp), .ndiv_o(ndiv), .idf_o(idf), .cp_o(cp),
    .busy_o(busy), .done_o(done), .timeout_o(tmo), .reject_o(rej),
    .rate_valid_o(rv));

  // analog PLL model: lock a fixed delay after power-up
  logic dead = 1'b0;
  int   lk_cnt = 0;
  always @(posedge clk) begin
    if (pdn) lk_cnt <= 0;
    else if (lk_cnt < 1000) lk_cnt <= lk_cnt + 1;
  end
  assign pll_lock = !pdn && !dead && (lk_cnt >= LOCK_DLY);

  int n_chk = 0, n_bad = 0;
  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic       rej;
    logic       pdn;
    logic       byp;
    logic       tmo;
    logic [7:0] n;
    logic [2:0] i;
    logic [4:0] c;
  } exp_t;
  exp_t  q[$];
  string tq[$];
  logic [7:0] en = 8'd50;
  logic [2:0] ei = 3'd1;
  logic [4:0] ec = 5'd6;

  task automatic push(input logic r, input logic p, input logic b,
                      input logic t, input string tag);
    exp_t e;
    e.rej = r; e.pdn = p; e.byp = b; e.tmo = t; e.n = en; e.i = ei; e.c = ec;
    q.push_back(e);
    tq.push_back(tag);
  endtask

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: scoreboard pop plus ordering observers
  int   fall_cyc = 0, tn = 0, ti = 0, tc = 0;
  logic pn = 1'b0, pi = 1'b0, pc = 1'b0, saw_pdn_rise = 1'b0;
  logic prev_pdn = 1'b1, prev_byp = 1'b1, prev2_pdn = 1'b1;
  logic [7:0] prev_n = 8'd50;
  logic [2:0] prev_i = 3'd1;
  logic [4:0] prev_c = 5'd6;
  always @(negedge clk) begin
    if (!rst) begin
      if (done || rej) begin
        if (q.size() == 0) begin
          check(1'b0, "R9", "unexpected event with empty queue", 1, 0);
        end else begin
          exp_t  e;
          string t;
          e = q.pop_front();
          t = tq.pop_front();
          check(rej == e.rej, t, "event kind reject", int'(rej), int'(e.rej));
          if (!e.rej) begin
            check(pdn == e.pdn, t, "power_down", int'(pdn), int'(e.pdn));
            check(byp == e.byp, t, "bypass", int'(byp), int'(e.byp));
            check(tmo == e.tmo, t, "timeout", int'(tmo), int'(e.tmo));
            check(ndiv == e.n && idf == e.i && cp == e.c, t, "divider set",
                  int'({ndiv, idf, cp}), int'({e.n, e.i, e.c}));
          end
        end
      end
      if (prev_pdn && !pdn) fall_cyc = cyc;
      if (!prev_pdn && pdn) begin
        saw_pdn_rise = 1'b1;
        check(prev_byp == 1'b1, "R5", "bypass before power-down", int'(prev_byp), 1);
      end
      if (prev_byp && !byp)
        check(pll_lock && !pdn, "R2", "lock present at mux switch", int'(pll_lock), 1);
      if (pdn && prev_pdn && prev2_pdn)
        check(!rv, "R8", "rate_valid while off", int'(rv), 0);
      if (ndiv != prev_n) begin tn = cyc; pn = pdn; end
      if (idf != prev_i)  begin ti = cyc; pi = pdn; end
      if (cp != prev_c)   begin tc = cyc; pc = pdn; end
      prev2_pdn = prev_pdn;
      prev_pdn = pdn; prev_byp = byp;
      prev_n = ndiv; prev_i = idf; prev_c = cp;
    end
  end

  task automatic pulse(input logic e, input logic d, input logic r);
    @(negedge clk);
    req_en = e; req_dis = d; req_rp = r;
    @(negedge clk);
    req_en = 1'b0; req_dis = 1'b0; req_rp = 1'b0;
  endtask

  task automatic do_req(input logic e, input logic d, input logic r, output int lat);
    @(negedge clk);
    req_en = e; req_dis = d; req_rp = r;
    lat = 0;
    do begin
      @(negedge clk);
      req_en = 1'b0; req_dis = 1'b0; req_rp = 1'b0;
      lat++;
    end while (!done);
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic set_div(input logic [7:0] n, input logic [2:0] i, input logic [4:0] c);
    n_in = n; i_in = i; c_in = c;
    en = n; ei = i; ec = c;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    int lat;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(pdn == 1'b1, "R1", "power_down", int'(pdn), 1);
    check(byp == 1'b1, "R1", "bypass", int'(byp), 1);
    check(!busy && !done && !tmo && !rej, "R1", "status flags",
          int'({busy, done, tmo, rej}), 0);
    check(rv == 1'b0, "R1", "rate_valid", int'(rv), 0);
    check(ndiv == 8'd50 && idf == 3'd1 && cp == 5'd6, "R1", "reset dividers",
          int'({ndiv, idf, cp}), int'({8'd50, 3'd1, 5'd6}));

    // R2 enable with lock
    push(1'b0, 1'b0, 1'b0, 1'b0, "R2");
    do_req(1'b1, 1'b0, 1'b0, lat);
    repeat (2) @(negedge clk);
    check(rv == 1'b1, "R8", "rate_valid when locked", int'(rv), 1);

    // R3 enable when already powered
    push(1'b0, 1'b0, 1'b0, 1'b0, "R3");
    do_req(1'b1, 1'b0, 1'b0, lat);
    check(lat == 1, "R3", "immediate done latency", lat, 1);

    // R5 disable
    push(1'b0, 1'b1, 1'b1, 1'b0, "R5");
    do_req(1'b0, 1'b1, 1'b0, lat);
    check(lat == 3, "R5", "disable latency", lat, 3);
    repeat (2) @(negedge clk);
    check(rv == 1'b0, "R8", "rate_valid after disable", int'(rv), 0);

    // R6 disable when already down
    push(1'b0, 1'b1, 1'b1, 1'b0, "R6");
    do_req(1'b0, 1'b1, 1'b0, lat);
    check(lat == 1, "R6", "immediate done latency", lat, 1);

    // R7 reprogram from powered-down state
    set_div(8'd80, 3'd2, 5'd12);
    push(1'b0, 1'b0, 1'b0, 1'b0, "R7");
    do_req(1'b0, 1'b0, 1'b1, lat);
    check(ti == tn + 1 && tc == ti + 1, "R7", "load order ndiv/idf/cp",
          (ti - tn) * 10 + (tc - ti), 11);
    check(pn && pi && pc, "R7", "loads while powered down", int'({pn, pi, pc}), 7);

    // R9 reprogram from running state, with a rejected request mid-way
    saw_pdn_rise = 1'b0;
    set_div(8'd120, 3'd3, 5'd17);
    pulse(1'b0, 1'b0, 1'b1);
    n_in = 8'd7; i_in = 3'd7; c_in = 5'd1;   // must not be captured
    @(negedge clk);
    check(busy == 1'b1, "R9", "busy during sequence", int'(busy), 1);
    push(1'b1, 1'b0, 1'b0, 1'b0, "R9");
    pulse(1'b1, 1'b0, 1'b0);
    push(1'b0, 1'b0, 1'b0, 1'b0, "R7");
    wait_done();
    check(saw_pdn_rise, "R7", "reprogram powered PLL down", int'(saw_pdn_rise), 1);

    // R10 enable + disable together: disable wins
    push(1'b0, 1'b1, 1'b1, 1'b0, "R10");
    do_req(1'b1, 1'b1, 1'b0, lat);
    // R10 reprogram + disable together while down: reprogram wins
    set_div(8'd64, 3'd1, 5'd9);
    push(1'b0, 1'b0, 1'b0, 1'b0, "R10");
    do_req(1'b0, 1'b1, 1'b1, lat);

    // R4 timeout
    push(1'b0, 1'b1, 1'b1, 1'b0, "R5");
    do_req(1'b0, 1'b1, 1'b0, lat);
    dead = 1'b1;
    push(1'b0, 1'b0, 1'b1, 1'b1, "R4");
    do_req(1'b1, 1'b0, 1'b0, lat);
    check(cyc - fall_cyc == LIMIT, "R4", "timeout window", cyc - fall_cyc, LIMIT);
    check(rv == 1'b0, "R8", "rate_valid without lock", int'(rv), 0);
    push(1'b0, 1'b0, 1'b1, 1'b0, "R4");
    do_req(1'b1, 1'b0, 1'b0, lat);
    check(lat == 1, "R4", "timeout clear on next request", lat, 1);

    // recovery: full down/up with lock restored
    dead = 1'b0;
    push(1'b0, 1'b1, 1'b1, 1'b0, "R5");
    do_req(1'b0, 1'b1, 1'b0, lat);
    push(1'b0, 1'b0, 1'b0, 1'b0, "R2");
    do_req(1'b1, 1'b0, 1'b0, lat);

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R9", "scoreboard drained", q.size(), 0);
    finish_run();
  end
endmodule